// File: doc/BRIEF.md
# Instruction Timing Throttle

This block lets a fast processor core run legacy software at the pace of a 3 MHz original processor. It does not execute instructions itself. The core signals the first cycle of each instruction, along with a small opcode class and the source and destination addressing modes, and later signals the cycle in which the instruction finishes. At the start the block computes a reference cycle count: a base count from a small class ROM plus a fixed fetch cost for each operand's addressing mode. It scales that count by the fast-clock to 3 MHz ratio to get a target in fast ticks. When the instruction finishes early, a hold output stalls the core's next fetch until the whole instruction has taken exactly the target number of ticks. When the core was already slower, no padding is added.

A second, independent path stretches each memory access by a selectable number of wait states (0 to 255). The count comes either from board switches or from a software control register. The control register also holds the throttle enable. It resets with the throttle on and the switches as the wait source, so legacy code starts at original speed. A readable output reports how many fast cycles the most recent instruction took, padding included.

Top module: `instr_pace_throttle`

## Requirements
- R1: After reset hold_o = 0, mem_wait_o = 0 and cyc_count_o = 0; the throttle is enabled and the wait count comes from sw_ws_i.
- R2: The base reference cycle count by instr_class_i is: 0→14, 1→10, 2→22, 3→26, 4→52, 5→92, 6→16, 7→12.
- R3: Each operand adds a fetch cost by its 2-bit mode: 0 register→0, 1 indirect→4, 2 indexed→8, 3 auto-increment→6. Source and destination costs are both added.
- R4: The target is T = (base + src cost + dst cost) × RATIO fast cycles. Let E be the number of cycles from the cycle with instr_start_i through the cycle with instr_end_i, both inclusive. With the throttle enabled, the instruction spans max(E, T) cycles up to its release.
- R5: hold_o rises in the cycle after instr_end_i and stays high for exactly T − E cycles; if E ≥ T, hold_o stays low.
- R6: On release, cyc_count_o latches the instruction's total cycle count (max(E, T) when throttled, E when not) and keeps it until the next release.
- R7: With the throttle enable bit cleared, hold_o never asserts.
- R8: A mem_req_i accepted while mem_wait_o is low makes mem_wait_o high for exactly N consecutive cycles, starting the next cycle, where N is the active wait count. N = 0 gives no wait. Requests made while mem_wait_o is high are ignored.
- R9: A write with ctrl_we_i loads the control register from ctrl_wdata_i: bit 9 selects the software wait count (1) or sw_ws_i (0), bit 8 is the throttle enable, and bits 7:0 are the software wait count.
- R10: An instruction whose start and end fall in the same cycle has E = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_start_i | input | 1 | First cycle of an instruction |
| instr_class_i | input | CLS_W | Opcode class for the base-count ROM |
| src_mode_i | input | 2 | Source addressing mode |
| dst_mode_i | input | 2 | Destination addressing mode |
| instr_end_i | input | 1 | Last execution cycle of the instruction |
| hold_o | output | 1 | Stall the next instruction fetch |
| mem_req_i | input | 1 | Start of a memory access |
| mem_wait_o | output | 1 | Insert a wait state |
| sw_ws_i | input | WS_W | Switch wait-state count |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | WS_W+2 | Control register write data |
| cyc_count_o | output | CNT_W | Cycles taken by the most recent instruction |

## Verification
The assertions check causality on every cycle. Padding only begins right after an instruction end while the throttle is on. A wait state only begins after a memory request. The cycle count only moves at a release. Whether the padding length equals the ROM value plus the mode costs, scaled and minus the elapsed cycles, can only be shown by the bench. It sweeps every class against every source and destination mode with a range of core run lengths, some shorter and some longer than the target. The bench also runs the wait-count sweep, the switch-versus-register selection, and the disabled-throttle runs.

// File: rtl/pace_pkg.sv
package pace_pkg;
  typedef enum logic [1:0] {
    MODE_REG  = 2'd0,
    MODE_IND  = 2'd1,
    MODE_IDX  = 2'd2,
    MODE_AINC = 2'd3
  } op_mode_e;

  localparam int unsigned REF_W = 8;

  function automatic logic [REF_W-1:0] mode_cost(input logic [1:0] m);
    case (op_mode_e'(m))
      MODE_REG:  mode_cost = 8'd0;
      MODE_IND:  mode_cost = 8'd4;
      MODE_IDX:  mode_cost = 8'd8;
      default:   mode_cost = 8'd6;
    endcase
  endfunction
endpackage

// File: rtl/ref_cycle_rom.sv
module ref_cycle_rom
  import pace_pkg::*;
#(
  parameter int unsigned CLS_W = 3
) (
  input  logic [CLS_W-1:0] class_i,
  input  logic [1:0]       src_mode_i,
  input  logic [1:0]       dst_mode_i,
  output logic [REF_W-1:0] ref_cyc_o
);
  logic [REF_W-1:0] base;

  always_comb begin
    case (class_i[2:0])
      3'd0: base = 8'd14;
      3'd1: base = 8'd10;
      3'd2: base = 8'd22;
      3'd3: base = 8'd26;
      3'd4: base = 8'd52;
      3'd5: base = 8'd92;
      3'd6: base = 8'd16;
      default: base = 8'd12;
    endcase
  end

  assign ref_cyc_o = base + mode_cost(src_mode_i) + mode_cost(dst_mode_i);
endmodule

// File: rtl/pace_ctrl.sv
module pace_ctrl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             end_i,
  input  logic [CNT_W-1:0] target_i,
  input  logic             thr_en_i,
  output logic             hold_o,
  output logic [CNT_W-1:0] cyc_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic             busy_q, pad_q;
  logic [CNT_W-1:0] elapsed_q, target_q, pad_cnt_q, cyc_q;
  logic [CNT_W-1:0] el_base, tgt, e_now;

  assign el_base = start_i ? '0 : elapsed_q;
  assign tgt     = start_i ? target_i : target_q;
  assign e_now   = (el_base == CMAX) ? CMAX : el_base + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      pad_q     <= 1'b0;
      elapsed_q <= '0;
      target_q  <= '0;
      pad_cnt_q <= '0;
      cyc_q     <= '0;
    end else if (pad_q) begin
      if (pad_cnt_q <= CNT_W'(1)) begin
        pad_q <= 1'b0;
        cyc_q <= target_q;
      end else begin
        pad_cnt_q <= pad_cnt_q - CNT_W'(1);
      end
    end else if (start_i || busy_q) begin
      target_q <= tgt;
      if (end_i) begin
        busy_q <= 1'b0;
        if (thr_en_i && (tgt > e_now)) begin
          pad_q     <= 1'b1;
          pad_cnt_q <= tgt - e_now;
        end else begin
          cyc_q <= e_now;
        end
      end else begin
        busy_q    <= 1'b1;
        elapsed_q <= e_now;
      end
    end
  end

  assign hold_o = pad_q;
  assign cyc_o  = cyc_q;
endmodule

// File: rtl/wait_gen.sv
module wait_gen #(
  parameter int unsigned WS_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic [WS_W-1:0] ws_i,
  output logic            wait_o
);
  logic [WS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - WS_W'(1);
    else if (req_i)         cnt_q <= ws_i;
  end

  assign wait_o = (cnt_q != '0);
endmodule

// File: rtl/instr_pace_throttle.sv
module instr_pace_throttle
  import pace_pkg::*;
#(
  parameter int unsigned CLS_W = 3,
  parameter int unsigned WS_W  = 8,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned RATIO = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_start_i,
  input  logic [CLS_W-1:0] instr_class_i,
  input  logic [1:0]       src_mode_i,
  input  logic [1:0]       dst_mode_i,
  input  logic             instr_end_i,
  output logic             hold_o,
  input  logic             mem_req_i,
  output logic             mem_wait_o,
  input  logic [WS_W-1:0]  sw_ws_i,
  input  logic             ctrl_we_i,
  input  logic [WS_W+1:0]  ctrl_wdata_i,
  output logic [CNT_W-1:0] cyc_count_o
);
  localparam int unsigned SEL_BIT = WS_W + 1;
  localparam int unsigned EN_BIT  = WS_W;

  logic            sw_sel_q, thr_en_q;
  logic [WS_W-1:0] ws_q, ws_eff;
  logic [REF_W-1:0] ref_cyc;
  logic [CNT_W-1:0] target;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_sel_q <= 1'b0;
      thr_en_q <= 1'b1;
      ws_q     <= '0;
    end else if (ctrl_we_i) begin
      sw_sel_q <= ctrl_wdata_i[SEL_BIT];
      thr_en_q <= ctrl_wdata_i[EN_BIT];
      ws_q     <= ctrl_wdata_i[WS_W-1:0];
    end
  end

  assign ws_eff = sw_sel_q ? ws_q : sw_ws_i;

  ref_cycle_rom #(.CLS_W(CLS_W)) u_rom (
    .class_i    (instr_class_i),
    .src_mode_i (src_mode_i),
    .dst_mode_i (dst_mode_i),
    .ref_cyc_o  (ref_cyc)
  );

  assign target = CNT_W'(ref_cyc) * CNT_W'(RATIO);

  pace_ctrl #(.CNT_W(CNT_W)) u_pace (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (instr_start_i),
    .end_i    (instr_end_i),
    .target_i (target),
    .thr_en_i (thr_en_q),
    .hold_o   (hold_o),
    .cyc_o    (cyc_count_o)
  );

  wait_gen #(.WS_W(WS_W)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (mem_req_i),
    .ws_i   (ws_eff),
    .wait_o (mem_wait_o)
  );
endmodule

// File: rtl/instr_pace_checker.sv
module instr_pace_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             instr_end_i,
  input logic             hold_o,
  input logic             mem_req_i,
  input logic             mem_wait_o,
  input logic [CNT_W-1:0] cyc_count_o,
  input logic             thr_en
);
  a_r5_hold_after_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(instr_end_i));

  a_r7_hold_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(thr_en));

  a_r8_wait_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_wait_o) |-> $past(mem_req_i));

  a_r6_count_on_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cyc_count_o) |-> (($past(instr_end_i) && !hold_o) || $fell(hold_o)));

  a_r1_reset_idle: assert property (@(posedge clk_i)
    !rst_ni |-> (!hold_o && !mem_wait_o && cyc_count_o == '0));
endmodule

bind instr_pace_throttle instr_pace_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_end_i (instr_end_i),
  .hold_o      (hold_o),
  .mem_req_i   (mem_req_i),
  .mem_wait_o  (mem_wait_o),
  .cyc_count_o (cyc_count_o),
  .thr_en      (thr_en_q)
);

// File: tb/instr_pace_throttle_bench.sv
module instr_pace_throttle_bench;
  localparam int RATIO = 4;
  localparam int CNT_W = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_start_i = 1'b0, instr_end_i = 1'b0;
  logic [2:0]  instr_class_i = '0;
  logic [1:0]  src_mode_i = '0, dst_mode_i = '0;
  logic        hold_o, mem_wait_o;
  logic        mem_req_i = 1'b0;
  logic [7:0]  sw_ws_i = 8'd3;
  logic        ctrl_we_i = 1'b0;
  logic [9:0]  ctrl_wdata_i = '0;
  logic [CNT_W-1:0] cyc_count_o;

  int checks = 0, errors = 0;
  bit thr_on = 1'b1;

  always #10 clk = ~clk;

  instr_pace_throttle #(.CLS_W(3), .WS_W(8), .CNT_W(CNT_W), .RATIO(RATIO)) u_instr_pace_throttle (
    .clk_i(clk), .rst_ni(rst_ni), .instr_start_i(instr_start_i),
    .instr_class_i(instr_class_i), .src_mode_i(src_mode_i), .dst_mode_i(dst_mode_i),
    .instr_end_i(instr_end_i), .hold_o(hold_o), .mem_req_i(mem_req_i),
    .mem_wait_o(mem_wait_o), .sw_ws_i(sw_ws_i), .ctrl_we_i(ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i), .cyc_count_o(cyc_count_o)
  );

  function automatic int base_of(int c);
    case (c)
      0: return 14; 1: return 10; 2: return 22; 3: return 26;
      4: return 52; 5: return 92; 6: return 16; default: return 12;
    endcase
  endfunction

  function automatic int cost_of(int m);
    case (m)
      0: return 0; 1: return 4; 2: return 8; default: return 6;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic ctrl_write(logic [9:0] v);
    @(negedge clk); ctrl_we_i = 1'b1; ctrl_wdata_i = v;
    @(negedge clk); ctrl_we_i = 1'b0;
  endtask

  task automatic run_instr(int c, int sm, int dm, int e, string req);
    int t, hold_n, exp_hold, exp_cyc;
    t = (base_of(c) + cost_of(sm) + cost_of(dm)) * RATIO;
    @(negedge clk);
    instr_start_i = 1'b1; instr_class_i = 3'(c);
    src_mode_i = 2'(sm); dst_mode_i = 2'(dm);
    instr_end_i = (e == 1);
    if (e > 1) begin
      @(negedge clk); instr_start_i = 1'b0;
      repeat (e - 2) @(negedge clk);
      instr_end_i = 1'b1;
    end
    @(negedge clk); instr_start_i = 1'b0; instr_end_i = 1'b0;
    hold_n = 0;
    while (hold_o && hold_n < 2000) begin
      hold_n++;
      @(negedge clk);
    end
    exp_hold = (thr_on && t > e) ? t - e : 0;
    exp_cyc  = (thr_on && t > e) ? t : e;
    chk({req, " hold cycles"}, hold_n, exp_hold);
    chk({req, " cycle count"}, int'(cyc_count_o), exp_cyc);
  endtask

  task automatic run_wait(int n, bit extra_req, string req);
    int w;
    @(negedge clk); mem_req_i = 1'b1;
    @(negedge clk); mem_req_i = extra_req;
    w = 0;
    while (mem_wait_o && w < 1000) begin
      w++;
      @(negedge clk);
      mem_req_i = 1'b0;
    end
    mem_req_i = 1'b0;
    chk(req, w, n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hold", int'(hold_o), 0);
    chk("R1 wait", int'(mem_wait_o), 0);
    chk("R1 count", int'(cyc_count_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 wait source is switches after reset (sw=3)
    run_wait(3, 1'b0, "R1 R8 switch wait after reset");

    // R2 R3 R4 R5 R6 sweep: every class and mode pair, E below and above T
    for (int c = 0; c < 8; c++)
      for (int s = 0; s < 4; s++)
        for (int d = 0; d < 4; d++) begin
          int e;
          e = 2 + ((c * 16 + s * 4 + d) * 37) % 300;
          run_instr(c, s, d, e, "R2 R3 R4 R5 R6 sweep");
        end

    // R10 single-cycle instruction
    run_instr(1, 0, 0, 1, "R10 one-cycle");
    run_instr(5, 2, 2, 1, "R10 one-cycle long");
    // R5 exact boundary E == T, and E = T-1
    run_instr(0, 0, 0, 56, "R5 equal");
    run_instr(0, 0, 0, 55, "R5 one short");

    // R9 R8 software wait count overrides switches
    ctrl_write(10'b11_0000_0101);
    sw_ws_i = 8'd9;
    run_wait(5, 1'b0, "R9 software wait");
    for (int n = 0; n < 12; n++) begin
      ctrl_write({2'b11, 8'(n)});
      run_wait(n, 1'b0, "R8 wait sweep");
    end
    ctrl_write(10'b11_1111_1111);
    run_wait(255, 1'b0, "R8 max wait");
    ctrl_write(10'b11_0000_0100);
    run_wait(4, 1'b1, "R8 request during wait ignored");
    ctrl_write(10'b01_0000_0111);
    run_wait(9, 1'b0, "R9 back to switches");
    sw_ws_i = 8'd0;
    run_wait(0, 1'b0, "R8 zero wait");

    // R7 throttle disabled
    ctrl_write(10'b00_0000_0000);
    thr_on = 1'b0;
    run_instr(5, 3, 3, 10, "R7 disabled");
    run_instr(4, 2, 1, 1, "R7 disabled one-cycle");
    ctrl_write(10'b01_0000_0000);
    thr_on = 1'b1;
    run_instr(2, 1, 3, 20, "R9 re-enabled");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule